// File: doc/BRIEF.md
# SDRAM Command-Mode Override Unit

This block sits between a simple host bus and the command pins of an SDRAM device. It holds a small writable command-mode register. While that register selects normal operation, every host access that falls inside the SDRAM address window becomes a row activation followed by a column read or write. Row, bank and column are taken from the offset of the access inside the window.

In any other mode, each access inside the window becomes exactly one fixed device command, whether the access is a read or a write. The fixed commands are NOP, precharge of all banks, mode-register load, extended mode-register load, auto-refresh and entry into deep power-down. For the two mode-register loads, the value written to the device is the access's address offset, not any data. Software uses these modes to walk the device through its power-up and configuration sequence with plain bus accesses.

The unit also keeps one sticky flag. It rises when an auto-refresh is issued while the banks are not known to be precharged.

Top module: `sdram_cmd_override`

## Requirements
- R1: After reset the mode reads 0, the pins carry NOP ({CS#,RAS#,CAS#,WE#}=0111, BA=0, A=0), CKE is high, `host_ready` is low and `prot_err` is low.
- R2: A config write stores `cfg_wdata[2:0]` as the mode, with the value 7 stored as 0 (normal). `cfg_rdata[2:0]` returns the mode and all higher read bits are zero.
- R3: In mode 0, an in-window access drives ACTIVATE (0011) for one cycle. It carries BA = offset[10:9] and A = offset[23:11]. The next cycle carries READ (0101) or WRITE (0100), with the same BA and A = offset[8:0] zero-extended, so A10 is 0.
- R4: In mode 1, an in-window access of either direction puts only NOP on the pins.
- R5: In mode 2, an access drives precharge-all (0010) with A10=1, all other A bits 0 and BA=0.
- R6: In mode 3, an access drives load-mode (0000) with BA=00 and A = offset[12:0]. Mode 5 drives the same command with BA=10.
- R7: In mode 4, an access drives auto-refresh (0001) with BA=0 and A=0.
- R8: In mode 6, an access drives 0110 with CKE low in that same cycle, and CKE then stays low. The next in-window access raises CKE with a NOP and issues no other command.
- R9: Every command cycle, or command pair in mode 0, is followed by exactly 2 NOP cycles. Then `host_ready` is high for exactly one cycle, also with NOP. Requests that arrive before that ready cycle has passed are ignored.
- R10: An access outside [base, base+2^24) issues no command and raises `host_ready` for one cycle, in the cycle after it is taken.
- R11: `prot_err` rises with an auto-refresh when the most recent command other than NOP and auto-refresh was not precharge-all, or when there was none. It then stays high until reset.
- R12: The mode used for an access is the one held when the access is taken. A config write sampled in the same cycle does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 32 | Mode register write data, bits [2:0] used |
| cfg_rdata | output | 32 | Mode register read value |
| host_req | input | 1 | One-cycle access request |
| host_wr | input | 1 | Access direction, 1 = write |
| host_addr | input | 32 | Access byte address |
| host_ready | output | 1 | One-cycle completion pulse |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | 2 | SDRAM bank address |
| sd_a | output | 13 | SDRAM address bus |
| prot_err | output | 1 | Sticky refresh-without-precharge flag |

## Verification
Each mode is driven with both read and write accesses, so that direction-independence of the forced commands is separated from the read/write choice in normal mode. Offsets are picked with distinct row, bank and column fields, plus an all-ones offset, so that a swapped or truncated field shows up on the pins. Refresh is tried right after precharge, after a second refresh, and after a mode load, which separates the "last real command" rule from simpler histories. Out-of-window addresses just below and just above the window, requests during a busy sequence, a config write in the very cycle an access is taken, and a power-down followed by a wake-up access cover the edges of the sequencing.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    MD_NORMAL = 3'd0,
    MD_NOP    = 3'd1,
    MD_PALL   = 3'd2,
    MD_LMR    = 3'd3,
    MD_REF    = 3'd4,
    MD_ELMR   = 3'd5,
    MD_DPD    = 3'd6,
    MD_RSVD   = 3'd7
  } mode_e;

  // {CS#, RAS#, CAS#, WE#}
  typedef enum logic [3:0] {
    C_LMR  = 4'b0000,
    C_REF  = 4'b0001,
    C_PALL = 4'b0010,
    C_ACT  = 4'b0011,
    C_WR   = 4'b0100,
    C_RD   = 4'b0101,
    C_DPD  = 4'b0110,
    C_NOP  = 4'b0111
  } cmd_e;

  function automatic logic [31:0] win_off(logic [31:0] addr, logic [31:0] base);
    return addr - base;
  endfunction

  function automatic logic win_hit(logic [31:0] addr, logic [31:0] base,
                                   int unsigned win_w);
    logic [31:0] d;
    d = addr - base;
    return (d >> win_w) == 32'd0;
  endfunction

  function automatic mode_e fold_mode(logic [2:0] raw);
    return (raw == 3'd7) ? MD_NORMAL : mode_e'(raw);
  endfunction

endpackage

// File: rtl/sdcmd_mode_reg.sv
module sdcmd_mode_reg
  import sdcmd_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output mode_e            mode,
  output logic [CFG_W-1:0] cfg_rdata
);
  mode_e mode_q;
  logic  unused_cfg_hi;

  assign unused_cfg_hi = ^cfg_wdata[CFG_W-1:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_NORMAL;
    end else if (cfg_we) begin
      mode_q <= fold_mode(cfg_wdata[2:0]);
    end
  end

  assign mode      = mode_q;
  assign cfg_rdata = CFG_W'(mode_q);
endmodule

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int ROW_W = 13,
  parameter int BA_W  = 2,
  parameter int OFF_W = 24
) (
  input  mode_e            mode,
  input  logic             wr,
  input  logic [OFF_W-1:0] off,
  input  logic             second,
  input  logic             wake,
  output cmd_e             cmd,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] a,
  output logic             cke_drop
);
  localparam int BANK_LSB = COL_W;
  localparam int ROW_LSB  = COL_W + BA_W;
  localparam int AP_BIT   = 10;

  logic [BA_W-1:0]  bank_f;
  logic [ROW_W-1:0] row_f;
  logic [ROW_W-1:0] col_f;
  logic [ROW_W-1:0] mrv_f;

  assign bank_f = off[BANK_LSB +: BA_W];
  assign row_f  = off[ROW_LSB +: ROW_W];
  assign col_f  = ROW_W'(off[COL_W-1:0]);
  assign mrv_f  = off[ROW_W-1:0];

  always_comb begin
    cmd      = C_NOP;
    ba       = '0;
    a        = '0;
    cke_drop = 1'b0;
    if (wake) begin
      cmd = C_NOP;
    end else begin
      unique case (mode)
        MD_NOP:  cmd = C_NOP;
        MD_PALL: begin
          cmd = C_PALL;
          a   = ROW_W'(1) << AP_BIT;
        end
        MD_LMR:  begin
          cmd = C_LMR;
          a   = mrv_f;
        end
        MD_REF:  cmd = C_REF;
        MD_ELMR: begin
          cmd = C_LMR;
          ba  = BA_W'(2);
          a   = mrv_f;
        end
        MD_DPD:  begin
          cmd      = C_DPD;
          cke_drop = 1'b1;
        end
        default: begin
          ba = bank_f;
          if (!second) begin
            cmd = C_ACT;
            a   = row_f;
          end else begin
            cmd = wr ? C_WR : C_RD;
            a   = col_f;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          OFF_W   = 24,
  parameter int          COL_W   = 9,
  parameter int          ROW_W   = 13,
  parameter int          BA_W    = 2,
  parameter int          GAP_CYC = 2,
  parameter logic [31:0] BASE    = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              host_ready,
  output cmd_e              pin_cmd,
  output logic [BA_W-1:0]   pin_ba,
  output logic [ROW_W-1:0]  pin_a,
  output logic              pin_cke,
  output logic              acc_take,
  output logic              iss_vld,
  output cmd_e              iss_cmd
);
  localparam int CNT_W = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_RW, S_GAP} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  mode_e            cap_mode;
  logic             cap_wr;
  logic [OFF_W-1:0] cap_off;
  logic             pd_q;
  logic             ready_q;
  cmd_e             cmd_q;
  logic [BA_W-1:0]  ba_q;
  logic [ROW_W-1:0] a_q;
  logic             cke_q;

  logic [31:0]      off_full;
  logic             hit;
  logic             take_mem;
  logic             unused_off_hi;

  mode_e            dec_mode;
  logic             dec_wr;
  logic [OFF_W-1:0] dec_off;
  logic             dec_second;
  logic             dec_wake;
  cmd_e             dec_cmd;
  logic [BA_W-1:0]  dec_ba;
  logic [ROW_W-1:0] dec_a;
  logic             dec_cke_drop;

  assign off_full      = win_off(32'(host_addr), BASE);
  assign hit           = win_hit(32'(host_addr), BASE, OFF_W);
  assign unused_off_hi = ^off_full[31:OFF_W];

  assign acc_take = (st_q == S_IDLE) && host_req;
  assign take_mem = acc_take && hit;

  assign dec_mode   = (st_q == S_IDLE) ? mode    : cap_mode;
  assign dec_wr     = (st_q == S_IDLE) ? host_wr : cap_wr;
  assign dec_off    = (st_q == S_IDLE) ? off_full[OFF_W-1:0] : cap_off;
  assign dec_second = (st_q == S_RW);
  assign dec_wake   = (st_q == S_IDLE) && pd_q;

  sdcmd_decode #(
    .COL_W(COL_W), .ROW_W(ROW_W), .BA_W(BA_W), .OFF_W(OFF_W)
  ) u_dec (
    .mode    (dec_mode),
    .wr      (dec_wr),
    .off     (dec_off),
    .second  (dec_second),
    .wake    (dec_wake),
    .cmd     (dec_cmd),
    .ba      (dec_ba),
    .a       (dec_a),
    .cke_drop(dec_cke_drop)
  );

  assign iss_vld = take_mem || (st_q == S_RW);
  assign iss_cmd = dec_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      cap_mode <= MD_NORMAL;
      cap_wr   <= 1'b0;
      cap_off  <= '0;
      pd_q     <= 1'b0;
      ready_q  <= 1'b0;
      cmd_q    <= C_NOP;
      ba_q     <= '0;
      a_q      <= '0;
      cke_q    <= 1'b1;
    end else begin
      ready_q <= 1'b0;
      cmd_q   <= C_NOP;
      ba_q    <= '0;
      a_q     <= '0;
      unique case (st_q)
        S_IDLE: begin
          if (acc_take) begin
            if (!hit) begin
              ready_q <= 1'b1;
            end else begin
              cap_mode <= mode;
              cap_wr   <= host_wr;
              cap_off  <= off_full[OFF_W-1:0];
              cmd_q    <= dec_cmd;
              ba_q     <= dec_ba;
              a_q      <= dec_a;
              cnt_q    <= '0;
              if (pd_q) begin
                cke_q <= 1'b1;
                pd_q  <= 1'b0;
                st_q  <= S_GAP;
              end else if (mode == MD_NORMAL) begin
                st_q <= S_RW;
              end else begin
                st_q <= S_GAP;
                if (dec_cke_drop) begin
                  cke_q <= 1'b0;
                  pd_q  <= 1'b1;
                end
              end
            end
          end
        end
        S_RW: begin
          cmd_q <= dec_cmd;
          ba_q  <= dec_ba;
          a_q   <= dec_a;
          cnt_q <= '0;
          st_q  <= S_GAP;
        end
        default: begin
          if (cnt_q == CNT_W'(GAP_CYC)) begin
            ready_q <= 1'b1;
            st_q    <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign host_ready = ready_q;
  assign pin_cmd    = cmd_q;
  assign pin_ba     = ba_q;
  assign pin_a      = a_q;
  assign pin_cke    = cke_q;
endmodule

// File: rtl/sdcmd_proto_mon.sv
module sdcmd_proto_mon
  import sdcmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic iss_vld,
  input  cmd_e iss_cmd,
  output logic ref_bad,
  output logic prot_err
);
  logic last_pall_q;
  logic err_q;

  assign ref_bad = iss_vld && (iss_cmd == C_REF) && !last_pall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_pall_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (iss_vld && iss_cmd != C_NOP && iss_cmd != C_REF) begin
        last_pall_q <= (iss_cmd == C_PALL);
      end
      if (ref_bad) begin
        err_q <= 1'b1;
      end
    end
  end

  assign prot_err = err_q;
endmodule

// File: rtl/sdram_cmd_override.sv
module sdram_cmd_override
  import sdcmd_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          CFG_W   = 32,
  parameter int          WIN_W   = 24,
  parameter int          COL_W   = 9,
  parameter int          ROW_W   = 13,
  parameter int          BA_W    = 2,
  parameter int          GAP_CYC = 2,
  parameter logic [31:0] BASE    = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              host_ready,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic              prot_err
);
  mode_e mode;
  cmd_e  pin_cmd;
  cmd_e  iss_cmd;
  logic  iss_vld;
  logic  acc_take;
  logic  ref_bad;

  sdcmd_mode_reg #(.CFG_W(CFG_W)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .mode     (mode),
    .cfg_rdata(cfg_rdata)
  );

  sdcmd_seq #(
    .ADDR_W(ADDR_W), .OFF_W(WIN_W), .COL_W(COL_W), .ROW_W(ROW_W),
    .BA_W(BA_W), .GAP_CYC(GAP_CYC), .BASE(BASE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .host_req  (host_req),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_ready(host_ready),
    .pin_cmd   (pin_cmd),
    .pin_ba    (sd_ba),
    .pin_a     (sd_a),
    .pin_cke   (sd_cke),
    .acc_take  (acc_take),
    .iss_vld   (iss_vld),
    .iss_cmd   (iss_cmd)
  );

  sdcmd_proto_mon u_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .iss_vld (iss_vld),
    .iss_cmd (iss_cmd),
    .ref_bad (ref_bad),
    .prot_err(prot_err)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'(pin_cmd);
endmodule

// File: rtl/sdcmd_chk.sv
module sdcmd_chk
  import sdcmd_pkg::*;
#(
  parameter int BA_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      cmd,
  input logic [BA_W-1:0] ba,
  input logic            a_ap,
  input logic            cke,
  input logic            host_ready,
  input logic            prot_err,
  input logic [2:0]      mode_rd,
  input logic            ref_bad
);
  assert_mode_no7_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rd != 3'd7);

  assert_act_then_rw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |=> ((cmd == C_RD || cmd == C_WR) && $stable(ba)));

  assert_pall_ap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PALL) |-> (a_ap && ba == '0));

  assert_cke_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd == C_DPD));

  assert_cke_low_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd == C_NOP || cmd == C_DPD));

  assert_single_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_NOP && cmd != C_ACT) |=> (cmd == C_NOP));

  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);

  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (cmd == C_NOP));

  assert_err_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_bad |=> prot_err);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> prot_err);
endmodule

bind sdram_cmd_override sdcmd_chk #(.BA_W(BA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd       ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .ba        (sd_ba),
  .a_ap      (sd_a[10]),
  .cke       (sd_cke),
  .host_ready(host_ready),
  .prot_err  (prot_err),
  .mode_rd   (cfg_rdata[2:0]),
  .ref_bad   (ref_bad)
);

// File: tb/sim_sdram_cmd_override.sv
module sim_sdram_cmd_override;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam logic [31:0] WSZ  = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_addr = '0;
  logic        host_ready;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_a;
  logic        prot_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  sdram_cmd_override u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_ready(host_ready), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .prot_err(prot_err)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] a;
    logic        cke;
    logic        rdy;
    string       tag;
  } ent_t;

  ent_t  q[$];
  ent_t  cur;
  int    m_mode = 0;
  bit    m_err = 0;
  bit    m_pall = 0;
  bit    m_pd = 0;
  string scn = "";

  function automatic void add(logic [3:0] c, logic [1:0] b, logic [12:0] a,
                              logic k, logic r, string t);
    ent_t e;
    e.cmd = c; e.ba = b; e.a = a; e.cke = k; e.rdy = r;
    e.tag = (scn != "") ? scn : t;
    q.push_back(e);
  endfunction

  function automatic void add_gap(string t);
    add(4'b0111, 2'd0, 13'd0, !m_pd, 1'b0, t);
    add(4'b0111, 2'd0, 13'd0, !m_pd, 1'b0, t);
    add(4'b0111, 2'd0, 13'd0, !m_pd, 1'b1, "R9");
  endfunction

  function automatic void model_accept(logic [31:0] ad, logic wr);
    int unsigned off;
    if (ad < BASE || ad >= BASE + WSZ) begin
      add(4'b0111, 2'd0, 13'd0, !m_pd, 1'b1, "R10");
      return;
    end
    off = ad - BASE;
    if (m_pd) begin
      m_pd = 0;
      add(4'b0111, 2'd0, 13'd0, 1'b1, 1'b0, "R8");
      add_gap("R8");
      return;
    end
    case (m_mode)
      1: begin
        add(4'b0111, 2'd0, 13'd0, 1'b1, 1'b0, "R4");
        add_gap("R4");
      end
      2: begin
        add(4'b0010, 2'd0, 13'd1024, 1'b1, 1'b0, "R5");
        m_pall = 1;
        add_gap("R5");
      end
      3: begin
        add(4'b0000, 2'd0, 13'(off % 8192), 1'b1, 1'b0, "R6");
        m_pall = 0;
        add_gap("R6");
      end
      4: begin
        add(4'b0001, 2'd0, 13'd0, 1'b1, 1'b0, "R7");
        if (!m_pall) m_err = 1;
        add_gap("R7");
      end
      5: begin
        add(4'b0000, 2'd2, 13'(off % 8192), 1'b1, 1'b0, "R6");
        m_pall = 0;
        add_gap("R6");
      end
      6: begin
        m_pd = 1;
        m_pall = 0;
        add(4'b0110, 2'd0, 13'd0, 1'b0, 1'b0, "R8");
        add_gap("R8");
      end
      default: begin
        add(4'b0011, 2'((off / 512) % 4), 13'((off / 2048) % 8192), 1'b1, 1'b0, "R3");
        add(wr ? 4'b0100 : 4'b0101, 2'((off / 512) % 4), 13'(off % 512), 1'b1, 1'b0, "R3");
        m_pall = 0;
        add_gap("R3");
      end
    endcase
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_mode = 0; m_err = 0; m_pall = 0; m_pd = 0;
      cur.cmd = 4'b0111; cur.ba = 0; cur.a = 0; cur.cke = 1; cur.rdy = 0; cur.tag = "R1";
    end else begin
      if (host_req && q.size() == 0) model_accept(host_addr, host_wr);
      if (q.size() > 0) begin
        cur = q.pop_front();
      end else begin
        cur.cmd = 4'b0111; cur.ba = 0; cur.a = 0; cur.cke = !m_pd; cur.rdy = 0;
        cur.tag = (scn != "") ? scn : "R9";
      end
      if (cfg_we) m_mode = (cfg_wdata[2:0] == 3'd7) ? 0 : int'(cfg_wdata[2:0]);
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != cur.cmd || sd_ba != cur.ba ||
          sd_a != cur.a || sd_cke != cur.cke || host_ready != cur.rdy) begin
        failures++;
        $display("FAIL %s t=%0t pins cmd=%b ba=%0d a=%h cke=%b rdy=%b expected cmd=%b ba=%0d a=%h cke=%b rdy=%b",
                 cur.tag, $time, {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, sd_ba, sd_a,
                 sd_cke, host_ready, cur.cmd, cur.ba, cur.a, cur.cke, cur.rdy);
      end
      checks++;
      if (cfg_rdata != 32'(m_mode)) begin
        failures++;
        $display("FAIL R2 t=%0t cfg_rdata=%h expected %h", $time, cfg_rdata, 32'(m_mode));
      end
      checks++;
      if (prot_err != m_err) begin
        failures++;
        $display("FAIL R11 t=%0t prot_err=%b expected %b", $time, prot_err, m_err);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL R9 watchdog cycles=%0d expected below %0d", cyc, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cfg_write(logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(logic wr, logic [31:0] ad);
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = ad;
    @(negedge clk);
    host_req = 1'b0;
    while (!host_ready) @(negedge clk);
  endtask

  task automatic check_eq(string t, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", t, got, exp);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state seen at the ports
    check_eq("R1 pins", {27'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke}, {27'd0, 4'b0111, 1'b1});
    check_eq("R1 ready/err", {30'd0, host_ready, prot_err}, 32'd0);
    check_eq("R1 mode", cfg_rdata, 32'd0);

    // R2: register write, fold of 7, upper bits ignored
    cfg_write(32'd5);  @(negedge clk); check_eq("R2 mode5", cfg_rdata, 32'd5);
    cfg_write(32'd7);  @(negedge clk); check_eq("R2 mode7", cfg_rdata, 32'd0);
    cfg_write(32'hFFFF_FFF9); @(negedge clk); check_eq("R2 upper", cfg_rdata, 32'd1);

    // R4: NOP mode, both directions
    access(1'b0, BASE + 32'h0000_1234);
    access(1'b1, BASE + 32'h00AB_CDEF);

    // R3: normal reads and writes with distinct fields
    cfg_write(32'd0);
    access(1'b0, BASE + {8'd0, 13'h1ABC, 2'd2, 9'h015});
    access(1'b1, BASE + {8'd0, 13'h0001, 2'd1, 9'h1FF});
    access(1'b0, BASE + 32'h00FF_FFFF);
    access(1'b1, BASE);

    // R10: just outside the window on both sides
    access(1'b0, BASE - 32'd1);
    access(1'b1, BASE + WSZ);

    // R5, R7, R11: refresh after precharge and after refresh: no flag
    cfg_write(32'd2); access(1'b1, BASE + 32'h0000_0400);
    cfg_write(32'd4); access(1'b0, BASE); access(1'b1, BASE + 32'd8);
    check_eq("R11 clean", {31'd0, prot_err}, 32'd0);

    // R6: mode-register loads use the offset
    cfg_write(32'd3); access(1'b1, BASE + 32'h0000_0033);
    access(1'b0, BASE + 32'h00FF_FFFF);
    cfg_write(32'd5); access(1'b0, BASE + 32'h0000_1FFF);
    access(1'b1, BASE + 32'h0012_0402);

    // R11: refresh after a load raises the sticky flag
    cfg_write(32'd4); access(1'b0, BASE);
    @(negedge clk); check_eq("R11 raised", {31'd0, prot_err}, 32'd1);
    cfg_write(32'd2); access(1'b0, BASE);
    @(negedge clk); check_eq("R11 sticky", {31'd0, prot_err}, 32'd1);

    // R9: request during a busy sequence is ignored
    scn = "R9";
    @(negedge clk); host_req = 1'b1; host_wr = 1'b0; host_addr = BASE;
    @(negedge clk); host_req = 1'b0;
    @(negedge clk); host_req = 1'b1; host_addr = BASE + 32'h40;
    @(negedge clk); host_req = 1'b0;
    while (!host_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    scn = "";

    // R12: config write in the accept cycle does not affect that access
    scn = "R12";
    @(negedge clk); host_req = 1'b1; host_addr = BASE + 32'h10;
    cfg_we = 1'b1; cfg_wdata = 32'd3;
    @(negedge clk); host_req = 1'b0; cfg_we = 1'b0;
    while (!host_ready) @(negedge clk);
    scn = "";
    @(negedge clk); check_eq("R12 new mode", cfg_rdata, 32'd3);

    // R8: power-down entry, idle with CKE low, wake-up access
    cfg_write(32'd6); access(1'b1, BASE + 32'h100);
    repeat (3) @(negedge clk);
    check_eq("R8 cke low", {31'd0, sd_cke}, 32'd0);
    cfg_write(32'd2); access(1'b0, BASE + 32'h200);
    @(negedge clk); check_eq("R8 cke high", {31'd0, sd_cke}, 32'd1);
    access(1'b0, BASE + 32'h200);

    // R2/R3: encoding 7 behaves as normal
    cfg_write(32'd7); access(1'b1, BASE + {8'd0, 13'h0F0F, 2'd3, 9'h0AA});

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule